// File: doc/BRIEF.md
# Reduced Power Mode Controller

This block holds the power-state control of a processor subsystem. Software writes a control word whose three scattered mode bits pick one of five operating states: running, idle, sleep, power-down or deep power-down. From that choice the block drives the processor clock enable, the shared peripheral clock enable, an oscillator stop request, two flash requests (standby and full power-off) and a request to switch off the internal DC-DC supply. The oscillator, flash, regulator and interrupt controller are outside the block and see only these request levels.

A second register holds one wakeup enable bit per external interrupt line. These enables are separate from the interrupt controller's own enables, so a line can bring the processor back from a stopped state without an interrupt being taken. When a wakeup arrives in sleep or power-down, the oscillator restarts and the block waits a settle count before turning the clocks back on; sleep skips the flash start-up share of that count. A wakeup that arrives while the block is still draining clocks on the way into a stopped state cancels the entry. The control word also carries a brown-out reset disable bit that masks the lower-threshold brown-out reset while leaving the higher-threshold brown-out interrupt alone.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After a synchronous active-low reset the mode field is 000, the brown-out reset disable bit is 0 and all wakeup enables are 0; both clock enables are 1 and the oscillator stop, flash standby, flash power-off and supply shutdown requests are 0.
- R2: The control register (address 0) reads back with mode bit 2 in bit 7, mode bits 1:0 in bits 1:0 and the brown-out reset disable in bit 2; bits 6:3 ignore writes and read 0. The wakeup enable register (address 1) holds bit n for external line n and reads back as written.
- R3: The valid mode codes are 000 running, 001 idle, 101 sleep, 010 power-down and 110 deep power-down. A control write carrying any other mode code (011, 100, 111) leaves the mode field unchanged, still updates the brown-out reset disable bit, and the block keeps running.
- R4: In idle the processor clock enable is 0 while the peripheral clock enable stays 1 and the oscillator keeps running; a pending interrupt from the interrupt controller or an external line with its wakeup enable set returns the block to running on the next clock edge.
- R5: After a sleep or power-down code is latched, the block spends ENTRY_CYCLES cycles with both clocks off and the oscillator running, then raises the oscillator stop request.
- R6: While stopped in sleep the flash standby request is 1 and the flash power-off request is 0; while stopped in power-down the flash power-off request is 1 and the standby request is 0.
- R7: In sleep and power-down only an external line whose wakeup enable bit is set wakes the block; pending interrupts from the interrupt controller and lines with a cleared enable have no effect.
- R8: After a wakeup event in the stopped state the oscillator stop request drops at the next edge, and the processor clock enable returns SETTLE_OSC + SETTLE_FLASH + 1 edges after the event for power-down and SETTLE_OSC + 1 edges for sleep.
- R9: Each return to running from idle, sleep or power-down clears the mode field to 000 in the same edge.
- R10: An enabled wakeup seen during the entry cycles of sleep or power-down cancels the entry at the next edge: the block is running again, the mode field reads 000 and the oscillator stop request is never raised.
- R11: Deep power-down stops both clocks, raises the oscillator stop, flash power-off and supply shutdown requests, ignores register writes and all wakeups, and is left only by reset.
- R12: The brown-out reset output equals the lower-threshold detect input while the disable bit is 0 and is 0 while it is 1; the brown-out interrupt output follows the higher-threshold detect input regardless of the disable bit.
- R13: The processor clock enable is never 1 while the peripheral clock enable is 0 or the oscillator stop request is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on control clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 0 control word, 1 wakeup enables |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register |
| ext_irq | input | NUM_EINT | External interrupt line levels, synchronous to clk |
| irq_pending | input | 1 | Any enabled interrupt pending in the interrupt controller |
| bod_low | input | 1 | Lower-threshold brown-out detect |
| bod_high | input | 1 | Higher-threshold brown-out detect |
| cpu_clk_en | output | 1 | Processor clock enable |
| periph_clk_en | output | 1 | Peripheral clock enable |
| osc_stop | output | 1 | Oscillator stop request |
| flash_standby | output | 1 | Flash standby request |
| flash_pd | output | 1 | Flash power-off request |
| dcdc_off | output | 1 | Internal supply shutdown request |
| bod_reset | output | 1 | Brown-out reset request |
| bod_irq | output | 1 | Brown-out interrupt request |

## Verification
On every cycle the assertions guard the ordering of the clock and power outputs (the processor clock is never on without the peripheral clock and oscillator, supply shutdown only with everything else off), that deep power-down and an unwoken stopped state hold, that an entry with a wakeup aborts, that the oscillator stops only out of the entry phase, and that a reserved mode code leaves the mode field alone. The directed scenarios show what needs a chosen history: the exact wake latencies of sleep against power-down, the length of the entry phase, the flash request that each stopped mode selects, which stimuli fail to wake a stopped block, the read-back layout, the brown-out masking, and that only reset leaves deep power-down.

// File: rtl/pmc_pkg.sv
// Package: shared codes and state type of the reduced power mode controller.
// Assumes the three mode bits are gathered as {bit7, bit1, bit0} of the
// control word before they are compared with these codes.
package pmc_pkg;

    // Mode codes as seen in the gathered three-bit mode field
    localparam logic [2:0] PM_RUN   = 3'b000;
    localparam logic [2:0] PM_IDLE  = 3'b001;
    localparam logic [2:0] PM_SLEEP = 3'b101;
    localparam logic [2:0] PM_PDOWN = 3'b010;
    localparam logic [2:0] PM_DEEP  = 3'b110;

    // Register select values
    localparam logic ADDR_CTRL = 1'b0;
    localparam logic ADDR_WAKE = 1'b1;

    // Control word bit positions
    localparam int BIT_M0   = 0;
    localparam int BIT_M1   = 1;
    localparam int BIT_BORD = 2;
    localparam int BIT_M2   = 7;

    // Controller states
    typedef enum logic [2:0] {
        ST_RUN   = 3'd0,
        ST_IDLE  = 3'd1,
        ST_ENTER = 3'd2,
        ST_STOP  = 3'd3,
        ST_WAKE  = 3'd4,
        ST_DEEP  = 3'd5
    } pmc_state_e;

    // True for the five defined mode codes
    function automatic logic code_is_valid(input logic [2:0] code);
        return (code == PM_RUN)   || (code == PM_IDLE) ||
               (code == PM_SLEEP) || (code == PM_PDOWN) ||
               (code == PM_DEEP);
    endfunction

endpackage

// File: rtl/pmc_regs.sv
// Module: pmc_regs
// Holds the software-visible control word (mode field, brown-out reset
// disable) and the per-line wakeup enables. Reserved mode codes are dropped
// at write time. Assumes NUM_EINT <= 8 and single-cycle write strobes.
module pmc_regs
    import pmc_pkg::*;
#(
    parameter int NUM_EINT = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_i,
    input  logic                addr_i,
    input  logic [7:0]          wdata_i,
    input  logic                wr_block_i,
    input  logic                mode_clr_i,
    output logic [7:0]          rdata_o,
    output logic [2:0]          mode_o,
    output logic                bord_o,
    output logic [NUM_EINT-1:0] wake_en_o
);

    logic [2:0]          mode_q;
    logic                bord_q;
    logic [NUM_EINT-1:0] wake_en_q;
    logic [2:0]          wr_code;
    logic                wr_ok;

    // Gather the scattered mode bits of the incoming word
    assign wr_code = {wdata_i[BIT_M2], wdata_i[BIT_M1], wdata_i[BIT_M0]};
    assign wr_ok   = wr_i && !wr_block_i;

    // Control word: mode field and brown-out reset disable
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= PM_RUN;
            bord_q <= 1'b0;
        end else begin
            if (wr_ok && addr_i == ADDR_CTRL) begin
                bord_q <= wdata_i[BIT_BORD];
                if (code_is_valid(wr_code)) begin
                    mode_q <= wr_code;
                end
            end
            if (mode_clr_i) begin
                mode_q <= PM_RUN;
            end
        end
    end

    // Wakeup enable register, one bit per external line
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wake_en_q <= '0;
        end else if (wr_ok && addr_i == ADDR_WAKE) begin
            wake_en_q <= wdata_i[NUM_EINT-1:0];
        end
    end

    // Read multiplexer with reserved bits forced to zero
    always_comb begin
        rdata_o = '0;
        if (addr_i == ADDR_CTRL) begin
            rdata_o[BIT_M2]   = mode_q[2];
            rdata_o[BIT_M1]   = mode_q[1];
            rdata_o[BIT_M0]   = mode_q[0];
            rdata_o[BIT_BORD] = bord_q;
        end else begin
            rdata_o[NUM_EINT-1:0] = wake_en_q;
        end
    end

    assign mode_o    = mode_q;
    assign bord_o    = bord_q;
    assign wake_en_o = wake_en_q;

    // R3
    rsvd_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ok && addr_i == ADDR_CTRL && !code_is_valid(wr_code) && !mode_clr_i)
        |=> (mode_q == $past(mode_q)));

endmodule

// File: rtl/pmc_wake.sv
// Module: pmc_wake
// Combines external lines with their wakeup enables and derives the idle
// exit condition and the brown-out outputs. Assumes ext_irq_i is already
// synchronous to clk.
module pmc_wake #(
    parameter int NUM_EINT = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_EINT-1:0] ext_irq_i,
    input  logic [NUM_EINT-1:0] wake_en_i,
    input  logic                irq_pending_i,
    input  logic                bod_low_i,
    input  logic                bod_high_i,
    input  logic                bord_i,
    output logic                wake_hit_o,
    output logic                idle_exit_o,
    output logic                bod_reset_o,
    output logic                bod_irq_o
);

    // Any external line whose wakeup enable is set
    assign wake_hit_o  = |(ext_irq_i & wake_en_i);

    // Idle also leaves on any interrupt the controller has enabled
    assign idle_exit_o = wake_hit_o || irq_pending_i;

    // Lower-threshold reset is maskable, upper-threshold interrupt is not
    assign bod_reset_o = bod_low_i && !bord_i;
    assign bod_irq_o   = bod_high_i;

    // R12
    bod_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bord_i |-> !bod_reset_o);

endmodule

// File: rtl/pmc_fsm.sv
// Module: pmc_fsm
// Mode state machine: follows the latched mode field, drains clocks before
// stopping the oscillator, runs the oscillator settle count on wakeup and
// clears the mode field on each return to running. Assumes SETTLE_OSC and
// ENTRY_CYCLES are at least 1.
module pmc_fsm
    import pmc_pkg::*;
#(
    parameter int ENTRY_CYCLES = 3,
    parameter int SETTLE_OSC   = 10,
    parameter int SETTLE_FLASH = 6
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] mode_i,
    input  logic       wake_hit_i,
    input  logic       idle_exit_i,
    output logic       mode_clr_o,
    output logic       deep_o,
    output logic       cpu_clk_en_o,
    output logic       periph_clk_en_o,
    output logic       osc_stop_o,
    output logic       flash_standby_o,
    output logic       flash_pd_o,
    output logic       dcdc_off_o
);

    localparam int MAX_CNT = ENTRY_CYCLES + SETTLE_OSC + SETTLE_FLASH;
    localparam int CNT_W   = $clog2(MAX_CNT + 1);
    localparam logic [CNT_W-1:0] ENTRY_LOAD = CNT_W'(ENTRY_CYCLES - 1);
    localparam logic [CNT_W-1:0] SLEEP_LOAD = CNT_W'(SETTLE_OSC - 1);
    localparam logic [CNT_W-1:0] PDOWN_LOAD = CNT_W'(SETTLE_OSC + SETTLE_FLASH - 1);

    pmc_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             is_sleep;

    assign is_sleep = (mode_i == PM_SLEEP);

    // Next-state, counter and mode-clear decision
    always_comb begin
        state_d    = state_q;
        cnt_d      = cnt_q;
        mode_clr_o = 1'b0;
        unique case (state_q)
            ST_RUN: begin
                if (mode_i == PM_IDLE) begin
                    state_d = ST_IDLE;
                end else if (mode_i == PM_SLEEP || mode_i == PM_PDOWN) begin
                    state_d = ST_ENTER;
                    cnt_d   = ENTRY_LOAD;
                end else if (mode_i == PM_DEEP) begin
                    state_d = ST_DEEP;
                end
            end
            ST_IDLE: begin
                if (idle_exit_i) begin
                    state_d    = ST_RUN;
                    mode_clr_o = 1'b1;
                end
            end
            ST_ENTER: begin
                if (wake_hit_i) begin
                    state_d    = ST_RUN;
                    mode_clr_o = 1'b1;
                end else if (cnt_q == '0) begin
                    state_d = ST_STOP;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            ST_STOP: begin
                if (wake_hit_i) begin
                    state_d = ST_WAKE;
                    cnt_d   = is_sleep ? SLEEP_LOAD : PDOWN_LOAD;
                end
            end
            ST_WAKE: begin
                if (cnt_q == '0) begin
                    state_d    = ST_RUN;
                    mode_clr_o = 1'b1;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            ST_DEEP: begin
                state_d = ST_DEEP;
            end
            default: begin
                state_d = ST_RUN;
            end
        endcase
    end

    // State and counter registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Clock and power request decode
    always_comb begin
        cpu_clk_en_o    = (state_q == ST_RUN);
        periph_clk_en_o = (state_q == ST_RUN) || (state_q == ST_IDLE);
        osc_stop_o      = (state_q == ST_STOP) || (state_q == ST_DEEP);
        flash_standby_o = (state_q == ST_STOP) && is_sleep;
        flash_pd_o      = ((state_q == ST_STOP) && !is_sleep) || (state_q == ST_DEEP);
        dcdc_off_o      = (state_q == ST_DEEP);
        deep_o          = (state_q == ST_DEEP);
    end

    // R11
    deep_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DEEP) |=> (state_q == ST_DEEP));

    // R7
    stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STOP && !wake_hit_i) |=> (state_q == ST_STOP));

    // R10
    entry_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ENTER && wake_hit_i) |=> (state_q == ST_RUN && mode_i == PM_RUN));

    // R5
    osc_from_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(osc_stop_o) && !dcdc_off_o) |-> ($past(state_q) == ST_ENTER));

endmodule

// File: rtl/pwr_mode_ctrl.sv
// Module: pwr_mode_ctrl (top)
// Reduced power mode controller: register file, wakeup combiner and mode
// state machine. Assumes a free-running always-on clock, synchronous
// external lines and NUM_EINT between 1 and 8.
module pwr_mode_ctrl #(
    parameter int NUM_EINT     = 8,
    parameter int ENTRY_CYCLES = 3,
    parameter int SETTLE_OSC   = 10,
    parameter int SETTLE_FLASH = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_wr,
    input  logic                reg_addr,
    input  logic [7:0]          reg_wdata,
    output logic [7:0]          reg_rdata,
    input  logic [NUM_EINT-1:0] ext_irq,
    input  logic                irq_pending,
    input  logic                bod_low,
    input  logic                bod_high,
    output logic                cpu_clk_en,
    output logic                periph_clk_en,
    output logic                osc_stop,
    output logic                flash_standby,
    output logic                flash_pd,
    output logic                dcdc_off,
    output logic                bod_reset,
    output logic                bod_irq
);

    logic [2:0]          mode;
    logic                bord;
    logic [NUM_EINT-1:0] wake_en;
    logic                mode_clr;
    logic                deep;
    logic                wake_hit;
    logic                idle_exit;

    // Software-visible registers
    pmc_regs #(.NUM_EINT(NUM_EINT)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_i       (reg_wr),
        .addr_i     (reg_addr),
        .wdata_i    (reg_wdata),
        .wr_block_i (deep),
        .mode_clr_i (mode_clr),
        .rdata_o    (reg_rdata),
        .mode_o     (mode),
        .bord_o     (bord),
        .wake_en_o  (wake_en)
    );

    // Wakeup and brown-out combiner
    pmc_wake #(.NUM_EINT(NUM_EINT)) u_wake (
        .clk           (clk),
        .rst_n         (rst_n),
        .ext_irq_i     (ext_irq),
        .wake_en_i     (wake_en),
        .irq_pending_i (irq_pending),
        .bod_low_i     (bod_low),
        .bod_high_i    (bod_high),
        .bord_i        (bord),
        .wake_hit_o    (wake_hit),
        .idle_exit_o   (idle_exit),
        .bod_reset_o   (bod_reset),
        .bod_irq_o     (bod_irq)
    );

    // Mode state machine
    pmc_fsm #(
        .ENTRY_CYCLES (ENTRY_CYCLES),
        .SETTLE_OSC   (SETTLE_OSC),
        .SETTLE_FLASH (SETTLE_FLASH)
    ) u_fsm (
        .clk             (clk),
        .rst_n           (rst_n),
        .mode_i          (mode),
        .wake_hit_i      (wake_hit),
        .idle_exit_i     (idle_exit),
        .mode_clr_o      (mode_clr),
        .deep_o          (deep),
        .cpu_clk_en_o    (cpu_clk_en),
        .periph_clk_en_o (periph_clk_en),
        .osc_stop_o      (osc_stop),
        .flash_standby_o (flash_standby),
        .flash_pd_o      (flash_pd),
        .dcdc_off_o      (dcdc_off)
    );

    // R13
    clk_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_clk_en |-> (periph_clk_en && !osc_stop));

    // R11
    deep_power_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dcdc_off |-> (osc_stop && flash_pd && !periph_clk_en && !flash_standby));

endmodule

// File: tb/tb_pwr_mode_ctrl.sv
// Directed bench for pwr_mode_ctrl: one task per scenario, each checking
// its own results against values worked out from the requirements.
module tb_pwr_mode_ctrl;

    localparam int NE     = 8;
    localparam int ENTRY  = 3;
    localparam int OSC    = 10;
    localparam int FLASH  = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_wr = 1'b0;
    logic          reg_addr = 1'b0;
    logic [7:0]    reg_wdata = '0;
    logic [7:0]    reg_rdata;
    logic [NE-1:0] ext_irq = '0;
    logic          irq_pending = 1'b0;
    logic          bod_low = 1'b0;
    logic          bod_high = 1'b0;
    logic          cpu_clk_en, periph_clk_en, osc_stop, flash_standby;
    logic          flash_pd, dcdc_off, bod_reset, bod_irq;

    int n_tests = 0;
    int n_fail  = 0;

    pwr_mode_ctrl #(
        .NUM_EINT(NE), .ENTRY_CYCLES(ENTRY), .SETTLE_OSC(OSC), .SETTLE_FLASH(FLASH)
    ) dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ext_irq(ext_irq),
        .irq_pending(irq_pending), .bod_low(bod_low), .bod_high(bod_high),
        .cpu_clk_en(cpu_clk_en), .periph_clk_en(periph_clk_en),
        .osc_stop(osc_stop), .flash_standby(flash_standby), .flash_pd(flash_pd),
        .dcdc_off(dcdc_off), .bod_reset(bod_reset), .bod_irq(bod_irq)
    );

    // 50 MHz clock
    always #10 clk = ~clk;

    task automatic check(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
        end
        @(negedge clk);
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk);
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic a, output logic [7:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    // Outputs packed {cpu, periph, osc_stop, standby, flash_pd, dcdc}
    function automatic int outs();
        return {cpu_clk_en, periph_clk_en, osc_stop, flash_standby, flash_pd, dcdc_off};
    endfunction

    task automatic t_reset();
        logic [7:0] d;
        @(negedge clk);
        rst_n = 1'b0;
        cycles(2);
        rst_n = 1'b1;
        #1;
        check("R1 outputs", outs(), 6'b110000);
        rd(1'b0, d); check("R1 control", d, 8'h00);
        rd(1'b1, d); check("R1 wake enables", d, 8'h00);
    endtask

    task automatic t_regs();
        logic [7:0] d;
        wr(1'b0, 8'h04);
        rd(1'b0, d); check("R2 disable bit readback", d, 8'h04);
        wr(1'b0, 8'h78);
        rd(1'b0, d); check("R2 reserved bits read 0", d, 8'h00);
        wr(1'b1, 8'hA5);
        rd(1'b1, d); check("R2 wake enable readback", d, 8'hA5);
        wr(1'b1, 8'h00);
    endtask

    task automatic t_bod();
        wr(1'b0, 8'h00);
        bod_low = 1'b1; bod_high = 1'b1; #1;
        check("R12 reset passes when enabled", bod_reset, 1);
        check("R12 interrupt follows", bod_irq, 1);
        wr(1'b0, 8'h04);
        #1;
        check("R12 reset masked", bod_reset, 0);
        check("R12 interrupt unaffected", bod_irq, 1);
        bod_high = 1'b0; #1;
        check("R12 interrupt drops", bod_irq, 0);
        bod_low = 1'b0;
        wr(1'b0, 8'h00);
    endtask

    task automatic t_reserved();
        logic [7:0] d;
        wr(1'b0, 8'h03); cycles(2);
        rd(1'b0, d); check("R3 code 011 ignored", d, 8'h00);
        check("R3 still running", outs(), 6'b110000);
        wr(1'b0, 8'h80); cycles(2);
        rd(1'b0, d); check("R3 code 100 ignored", d, 8'h00);
        wr(1'b0, 8'h87); cycles(2);
        rd(1'b0, d); check("R3 code 111 ignored, disable bit taken", d, 8'h04);
        check("R3 still running after 111", outs(), 6'b110000);
        wr(1'b0, 8'h00);
    endtask

    task automatic t_idle();
        logic [7:0] d;
        wr(1'b1, 8'h02);
        wr(1'b0, 8'h01); cycles(1);
        check("R4 idle outputs", outs(), 6'b010000);
        ext_irq = 8'h01; cycles(2);
        check("R4 idle ignores line without enable", outs(), 6'b010000);
        ext_irq = 8'h00;
        irq_pending = 1'b1; cycles(1);
        irq_pending = 1'b0;
        check("R4 idle exit on pending interrupt", cpu_clk_en, 1);
        rd(1'b0, d); check("R9 mode cleared after idle", d, 8'h00);
        wr(1'b0, 8'h01); cycles(1);
        ext_irq = 8'h02; cycles(1);
        ext_irq = 8'h00;
        check("R4 idle exit on enabled line", cpu_clk_en, 1);
        wr(1'b1, 8'h00);
    endtask

    // Enter sleep (is_sleep) or power-down, test non-waking stimuli, then wake
    task automatic t_stop(input logic is_sleep);
        logic [7:0] d;
        int n;
        int lat;
        lat = is_sleep ? OSC + 1 : OSC + FLASH + 1;
        wr(1'b1, 8'h01);
        wr(1'b0, is_sleep ? 8'h81 : 8'h02);
        cycles(1);
        check("R5 entry: clocks off, oscillator on", outs(), 6'b000000);
        cycles(ENTRY - 1);
        check("R5 oscillator still on at last entry cycle", osc_stop, 0);
        cycles(1);
        check("R5 oscillator stopped", osc_stop, 1);
        check("R6 flash request", {flash_standby, flash_pd}, is_sleep ? 2'b10 : 2'b01);
        ext_irq = 8'hFE; irq_pending = 1'b1; cycles(12);
        check("R7 no wake from disabled lines or controller", outs(),
              is_sleep ? 6'b001100 : 6'b001010);
        ext_irq = 8'h00; irq_pending = 1'b0;
        @(negedge clk);
        ext_irq = 8'h01;
        n = 0;
        do begin
            @(posedge clk); @(negedge clk);
            n++;
            if (n == 1) check("R8 oscillator restarts at next edge", osc_stop, 0);
        end while (!cpu_clk_en && n < 100);
        ext_irq = 8'h00;
        check(is_sleep ? "R8 sleep wake latency" : "R8 power-down wake latency", n, lat);
        rd(1'b0, d); check("R9 mode cleared after wake", d, 8'h00);
        wr(1'b1, 8'h00);
    endtask

    task automatic t_abort();
        logic [7:0] d;
        int stopped;
        wr(1'b1, 8'h10);
        wr(1'b0, 8'h02);
        cycles(1);
        check("R10 in entry phase", cpu_clk_en, 0);
        ext_irq = 8'h10;
        stopped = 0;
        cycles(1);
        if (osc_stop) stopped = 1;
        ext_irq = 8'h00;
        check("R10 running after abort", cpu_clk_en, 1);
        rd(1'b0, d); check("R10 mode cleared on abort", d, 8'h00);
        cycles(ENTRY + 2);
        if (osc_stop) stopped = 1;
        check("R10 oscillator never stopped", stopped, 0);
        check("R10 stays running", outs(), 6'b110000);
        wr(1'b1, 8'h00);
    endtask

    task automatic t_deep();
        logic [7:0] d;
        wr(1'b1, 8'hFF);
        wr(1'b0, 8'h82); cycles(1);
        check("R11 deep outputs", outs(), 6'b001011);
        ext_irq = 8'hFF; irq_pending = 1'b1; cycles(30);
        check("R11 no wake from deep", outs(), 6'b001011);
        ext_irq = 8'h00; irq_pending = 1'b0;
        wr(1'b0, 8'h04); wr(1'b1, 8'h00);
        rd(1'b0, d); check("R11 control write ignored", d, 8'h82);
        rd(1'b1, d); check("R11 wake write ignored", d, 8'hFF);
        t_reset();
        check("R11 reset leaves deep", dcdc_off, 0);
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_regs();
        t_bod();
        t_reserved();
        t_idle();
        t_stop(1'b1);
        t_stop(1'b0);
        t_abort();
        t_deep();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule